// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Coded Clock Modes

This block moves one byte at a time over a four-wire SPI link. A 4-bit mode input chooses the role and the clock. In the master codes the port makes its own serial clock from the system clock, either at one of three fixed ratios or at a rate set by an 8-bit reload value. In the slave codes the port follows a clock that arrives on its clock input, and the code also decides whether the select input gates the slave.

Software writes a byte with a single-cycle strobe. The byte goes out most significant bit first while a new byte comes in on the serial input. After eight clock periods the received byte appears on the read bus and a done flag rises. A write that arrives while a byte is still moving is dropped, and a collision flag records it. The serial clock is low when idle. The input is sampled on the rising clock edge and the output advances on the falling edge.

Top module: `spi_engine`

## Requirements
- R1: Mode 4'b0000 is master with the serial clock at the system clock divided by 2 (one system cycle high, one low).
- R2: Mode 4'b0001 is master at system clock divided by 8, and mode 4'b0010 is master at system clock divided by 32.
- R3: Mode 4'b1010 is master with the serial clock at the system clock divided by 2*(N+1), where N is the 8-bit reload input.
- R4: The data is MSB first. The serial input is sampled on each rising serial clock edge and the output shifts on each falling edge. After eight clock periods the received byte is placed on rd_data and done is set. An accepted write clears done.
- R5: In mode 4'b0100 the slave runs only while ss_n_i is low. While ss_n_i is high, serial clock edges are ignored, no byte completes and sdo_oe is low.
- R6: In mode 4'b0101 the slave runs from the serial clock input whatever level ss_n_i has.
- R7: In the slave modes, sck_i and ss_n_i each pass through two synchronizing flops, and an edge takes effect one cycle later. As a result, done rises at the third system clock edge after the final falling edge of sck_i.
- R8: Mode 4'b0011, and any code not named above, keeps the port idle: sck_o low, sdo_oe low, writes ignored, and done, wcol and rd_data unchanged.
- R9: A write while a byte is in progress leaves the shift data untouched and sets wcol. The next accepted write clears wcol.
- R10: After reset, sck_o, sdo_oe, done, wcol and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Role and clock-rate code |
| baud_reload | input | 8 | Reload value N for the programmable master rate |
| wr_en | input | 1 | One-cycle write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last byte received |
| done | output | 1 | Byte complete; cleared by an accepted write |
| wcol | output | 1 | Write collision seen |
| sck_o | output | 1 | Serial clock driven in master modes |
| sck_i | input | 1 | Serial clock received in slave modes |
| ss_n_i | input | 1 | Active-low slave select |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The hardest case to reach is the select-gated slave: it must sit through a full burst of clock edges while deselected and then still shift correctly once selected. The bench plays a remote master on sck_i and sdi. It loads a byte while ss_n_i is high, runs eight clock periods and confirms that nothing completes. It then lowers ss_n_i, exchanges a byte and checks both directions, including the exact cycle in which done rises after the last falling edge. The master collision case is reached by placing a second write in the middle of a divide-by-8 transfer with the serial input looped back. The received byte must then equal the first write.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef logic [3:0] spi_mode_t;

  localparam spi_mode_t MODE_M_FAST   = 4'b0000;
  localparam spi_mode_t MODE_M_MID    = 4'b0001;
  localparam spi_mode_t MODE_M_SLOW   = 4'b0010;
  localparam spi_mode_t MODE_RSVD     = 4'b0011;
  localparam spi_mode_t MODE_S_SEL    = 4'b0100;
  localparam spi_mode_t MODE_S_FREE   = 4'b0101;
  localparam spi_mode_t MODE_M_RELOAD = 4'b1010;

  localparam int HALF_MID  = 4;
  localparam int HALF_SLOW = 16;

  function automatic logic mode_master(spi_mode_t m);
    return (m == MODE_M_FAST) || (m == MODE_M_MID) ||
           (m == MODE_M_SLOW) || (m == MODE_M_RELOAD);
  endfunction

  function automatic logic mode_slave(spi_mode_t m);
    return (m == MODE_S_SEL) || (m == MODE_S_FREE);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == half - HW'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] baud_reload,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          wcol,
  output logic          sck_o,
  input  logic          sck_i,
  input  logic          ss_n_i,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          sdi
);
  localparam int HW  = RW + 1;
  localparam int BCW = $clog2(DW);

  logic [HW-1:0]  half;
  logic           tick;
  logic           is_m, is_s, slave_en, busy;
  logic           busy_m, phase, samp, sck_prev;
  logic [BCW-1:0] bits;
  logic [DW-1:0]  sh;
  logic [1:0]     pins_s;
  logic           sck_s, ss_s, sck_rise, sck_fall;
  logic           last_bit;

  spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({ss_n_i, sck_i}), .q(pins_s)
  );
  assign sck_s = pins_s[0];
  assign ss_s  = pins_s[1];

  always_comb begin
    case (mode)
      MODE_M_MID:    half = HW'(HALF_MID);
      MODE_M_SLOW:   half = HW'(HALF_SLOW);
      MODE_M_RELOAD: half = HW'(baud_reload) + HW'(1);
      default:       half = HW'(1);
    endcase
  end

  spi_baud #(.HW(HW)) u_baud (
    .clk(clk), .rst(rst), .run(is_m && busy_m), .half(half), .tick(tick)
  );

  assign is_m     = mode_master(mode);
  assign is_s     = mode_slave(mode);
  assign slave_en = (mode == MODE_S_FREE) || ((mode == MODE_S_SEL) && !ss_s);
  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;
  assign busy     = is_m ? busy_m : (slave_en && (phase || (bits != '0)));
  assign last_bit = (bits == BCW'(DW-1));
  assign sdo      = sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      sdo_oe   <= 1'b0;
      sck_o    <= 1'b0;
      busy_m   <= 1'b0;
      bits     <= '0;
      phase    <= 1'b0;
      samp     <= 1'b0;
      sh       <= '0;
      rd_data  <= '0;
      done     <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      sdo_oe   <= is_m || slave_en;
      if (!is_m) begin
        busy_m <= 1'b0;
        sck_o  <= 1'b0;
      end
      if (!is_m && !slave_en) begin
        bits  <= '0;
        phase <= 1'b0;
      end
      // master: sample on the rising toggle, shift on the falling toggle
      if (is_m && busy_m && tick) begin
        sck_o <= ~sck_o;
        if (!sck_o) begin
          samp <= sdi;
        end else begin
          sh <= {sh[DW-2:0], samp};
          if (last_bit) begin
            bits    <= '0;
            busy_m  <= 1'b0;
            done    <= 1'b1;
            rd_data <= {sh[DW-2:0], samp};
          end else begin
            bits <= bits + BCW'(1);
          end
        end
      end
      // slave: edges come from the synchronized pin
      if (slave_en) begin
        if (sck_rise) begin
          samp  <= sdi;
          phase <= 1'b1;
        end else if (sck_fall && phase) begin
          phase <= 1'b0;
          sh    <= {sh[DW-2:0], samp};
          if (last_bit) begin
            bits    <= '0;
            done    <= 1'b1;
            rd_data <= {sh[DW-2:0], samp};
          end else begin
            bits <= bits + BCW'(1);
          end
        end
      end
      if (wr_en && (is_m || is_s)) begin
        if (busy) begin
          wcol <= 1'b1;
        end else begin
          sh   <= wr_data;
          done <= 1'b0;
          wcol <= 1'b0;
          if (is_m) begin
            busy_m <= 1'b1;
            sck_o  <= 1'b0;
            bits   <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_engine_chk.sv
module spi_engine_chk
  import spi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] mode,
  input logic       wr_en,
  input logic       busy_m,
  input logic       sck_o,
  input logic       sdo_oe,
  input logic       done,
  input logic       wcol
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!mode_master(mode) && !mode_slave(mode)) |=> !sdo_oe); // R8

  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mode_master(mode) |=> !sck_o); // R8

  AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_M_FAST && $past(mode) == MODE_M_FAST && busy_m && $past(busy_m))
      |-> (sck_o != $past(sck_o))); // R1

  AST_DONE_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(wr_en)); // R4

  AST_WCOL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol) |-> $past(wr_en)); // R9

  AST_RSVD_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RSVD && $past(mode) == MODE_RSVD) |-> !$rose(done)); // R8
endmodule

bind spi_engine spi_engine_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .busy_m(busy_m),
  .sck_o(sck_o), .sdo_oe(sdo_oe), .done(done), .wcol(wcol)
);

// File: tb/sim_spi_engine.sv
module sim_spi_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mode = 4'b0011;
  logic [7:0] baud = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       done, wcol, sck_o, sdo, sdo_oe;
  logic       sck_i = 1'b0;
  logic       ss_n_i = 1'b1;
  logic       loop = 1'b0;
  logic       sdi_drv = 1'b0;
  logic       sdi;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  assign sdi = loop ? sdo : sdi_drv;

  spi_engine u0 (
    .clk(clk), .rst(rst), .mode(mode), .baud_reload(baud),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .wcol(wcol), .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  task automatic chk(input string rq, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference model, advanced on every rising clock
  int   m_cnt, m_bits;
  logic m_busy, m_sck, m_phase, m_samp, m_oe, m_done, m_wcol;
  logic [7:0] m_sh, m_rd;
  logic m_k1, m_k2, m_kp, m_s1, m_s2;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_bits = 0; m_busy = 0; m_sck = 0; m_phase = 0; m_samp = 0;
      m_oe = 0; m_done = 0; m_wcol = 0; m_sh = 0; m_rd = 0;
      m_k1 = 0; m_k2 = 0; m_kp = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      automatic bit ism = (mode == 4'd0) || (mode == 4'd1) || (mode == 4'd2) || (mode == 4'd10);
      automatic bit iss = (mode == 4'd4) || (mode == 4'd5);
      automatic bit sen = (mode == 4'd5) || (mode == 4'd4 && !m_s2);
      automatic bit rise = m_k2 && !m_kp;
      automatic bit fall = !m_k2 && m_kp;
      automatic int half = (mode == 4'd1) ? 4 : (mode == 4'd2) ? 16 :
                           (mode == 4'd10) ? int'(baud) + 1 : 1;
      automatic bit tick = ism && m_busy && (m_cnt == half - 1);
      automatic bit busy = ism ? m_busy : (sen && (m_phase || m_bits != 0));
      automatic logic o_sck = m_sck;
      automatic logic [7:0] o_sh = m_sh;
      automatic logic o_samp = m_samp;
      automatic bit o_phase = m_phase;
      automatic int o_bits = m_bits;
      if (!(ism && m_busy)) m_cnt = 0;
      else if (m_cnt == half - 1) m_cnt = 0;
      else m_cnt++;
      m_oe = ism || sen;
      if (!ism) begin m_busy = 0; m_sck = 0; end
      if (!ism && !sen) begin m_bits = 0; m_phase = 0; end
      if (tick) begin
        m_sck = !o_sck;
        if (!o_sck) m_samp = sdi;
        else begin
          m_sh = {o_sh[6:0], o_samp};
          if (o_bits == 7) begin m_bits = 0; m_busy = 0; m_done = 1; m_rd = m_sh; end
          else m_bits = o_bits + 1;
        end
      end
      if (sen) begin
        if (rise) begin m_samp = sdi; m_phase = 1; end
        else if (fall && o_phase) begin
          m_phase = 0;
          m_sh = {o_sh[6:0], o_samp};
          if (o_bits == 7) begin m_bits = 0; m_done = 1; m_rd = m_sh; end
          else m_bits = o_bits + 1;
        end
      end
      if (wr_en && (ism || iss)) begin
        if (busy) m_wcol = 1;
        else begin
          m_sh = wr_data; m_done = 0; m_wcol = 0;
          if (ism) begin m_busy = 1; m_sck = 0; m_bits = 0; end
        end
      end
      m_kp = m_k2; m_k2 = m_k1; m_k1 = sck_i;
      m_s2 = m_s1; m_s1 = ss_n_i;
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R1", sck_o, m_sck, "model sck_o");
      chk("R4", sdo, m_sh[7], "model sdo");
      chk("R5", sdo_oe, m_oe, "model sdo_oe");
      chk("R4", rd_data, m_rd, "model rd_data");
      chk("R7", done, m_done, "model done");
      chk("R9", wcol, m_wcol, "model wcol");
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic master_xfer(input logic [3:0] md, input logic [7:0] n,
                             input logic [7:0] d, input int half,
                             input logic lp, input logic sv,
                             input logic [7:0] exp_rx, input string rq);
    logic [7:0] cap = '0;
    int t = 0;
    int last = -1;
    int per = -1;
    logic ps;
    mode = md; baud = n; loop = lp; sdi_drv = sv;
    cyc(3);
    wr(d);
    ps = sck_o;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (sck_o && !ps) begin
        cap = {cap[6:0], sdo};
        if (last >= 0 && per < 0) per = t - last;
        last = t;
      end
      ps = sck_o;
    end
    chk(rq, per, 2 * half, "sck period in system cycles");
    chk("R4", done, 1, "done after eight periods");
    chk("R4", rd_data, exp_rx, "received byte");
    chk("R4", cap, d, "MSB-first transmit order");
  endtask

  task automatic remote_xfer(input logic [7:0] b, output logic [7:0] got,
                             input bit exp_done);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      sdi_drv = b[i];
      cyc(6);
      sck_i = 1'b1;
      got = {got[6:0], sdo};
      cyc(6);
      sck_i = 1'b0;
      if (i == 0 && exp_done) begin
        cyc(2);
        chk("R7", done, 0, "done two edges after last fall");
        cyc(1);
        chk("R7", done, 1, "done three edges after last fall");
        cyc(3);
      end else begin
        cyc(6);
      end
    end
  endtask

  initial begin
    logic [7:0] got;
    cyc(5);
    chk("R10", sck_o, 0, "reset sck_o");
    chk("R10", sdo_oe, 0, "reset sdo_oe");
    chk("R10", done, 0, "reset done");
    chk("R10", wcol, 0, "reset wcol");
    chk("R10", rd_data, 0, "reset rd_data");
    rst = 1'b0;
    cmp_on = 1'b1;
    cyc(2);

    master_xfer(4'b0000, 8'd0, 8'hA5, 1, 1'b1, 1'b0, 8'hA5, "R1");
    master_xfer(4'b0001, 8'd0, 8'h3C, 4, 1'b1, 1'b0, 8'h3C, "R2");
    master_xfer(4'b0010, 8'd0, 8'h81, 16, 1'b1, 1'b0, 8'h81, "R2");
    master_xfer(4'b1010, 8'd2, 8'h5A, 3, 1'b1, 1'b0, 8'h5A, "R3");
    master_xfer(4'b1010, 8'd0, 8'hC3, 1, 1'b1, 1'b0, 8'hC3, "R3");
    master_xfer(4'b0000, 8'd0, 8'h00, 1, 1'b0, 1'b1, 8'hFF, "R1");

    // R9: collision in the middle of a divide-by-8 transfer
    mode = 4'b0001; loop = 1'b1;
    cyc(2);
    wr(8'h96);
    cyc(5);
    wr(8'h11);
    chk("R9", wcol, 1, "wcol after write while busy");
    while (!done) @(negedge clk);
    chk("R9", rd_data, 8'h96, "ignored write left data intact");
    wr(8'h22);
    chk("R9", wcol, 0, "accepted write clears wcol");
    chk("R4", done, 0, "accepted write clears done");
    while (!done) @(negedge clk);
    chk("R4", rd_data, 8'h22, "loopback byte");

    // R8: reserved and undefined codes stay idle
    mode = 4'b0011;
    cyc(2);
    wr(8'h77);
    cyc(40);
    chk("R8", sck_o, 0, "reserved sck_o");
    chk("R8", sdo_oe, 0, "reserved sdo_oe");
    chk("R8", done, 1, "reserved write ignored, done kept");
    chk("R8", rd_data, 8'h22, "reserved rd_data kept");
    chk("R8", wcol, 0, "reserved wcol kept");
    mode = 4'b0110;
    cyc(3);
    chk("R8", sdo_oe, 0, "undefined code sdo_oe");

    // R6: slave with select ignored
    loop = 1'b0; ss_n_i = 1'b1; mode = 4'b0101;
    cyc(4);
    wr(8'hE7);
    remote_xfer(8'h4B, got, 1'b1);
    chk("R6", rd_data, 8'h4B, "slave received byte");
    chk("R6", got, 8'hE7, "slave sent byte MSB first");
    chk("R6", sdo_oe, 1, "slave drives with select high");

    // R5: select-gated slave, first deselected then selected
    mode = 4'b0100;
    cyc(4);
    wr(8'h3C);
    remote_xfer(8'hFF, got, 1'b0);
    chk("R5", done, 0, "deselected slave does not complete");
    chk("R5", sdo_oe, 0, "deselected slave not driving");
    chk("R5", rd_data, 8'h4B, "deselected slave rd_data kept");
    ss_n_i = 1'b0;
    cyc(4);
    chk("R5", sdo_oe, 1, "selected slave driving");
    remote_xfer(8'h2D, got, 1'b1);
    chk("R5", rd_data, 8'h2D, "selected slave received byte");
    chk("R5", got, 8'h3C, "selected slave sent byte");

    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule